// File: doc/BRIEF.md
# Sound Command Mailbox with Maskable NMI Delivery

This block hands a single command byte from a host processor to an audio processor. Each host write stores the byte in a holding register that the audio side reads, and it asks for a non-maskable interrupt (NMI) on the audio side. The audio side controls whether that NMI is delivered, using two strobes: one opens the gate and one closes it.

A request that arrives while the gate is closed is not lost. It is kept as a single pending bit. The NMI is issued on the next strobe that opens the gate. Several host writes made while the gate is closed collapse into one pending request, and the holding register always shows the most recent byte.

The NMI output is a registered pulse that is high for one clock. It rises in the cycle after the edge that samples its cause. Reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `scl_sound_mailbox`

## Requirements
- R1: On the clock edge that samples `cmd_wr` high, the whole `cmd_data` byte is stored, and `cmd_q` shows it from the following cycle.
- R2: A host write while the gate is open drives `nmi_pulse` high for exactly the one cycle after the sampling edge.
- R3: A host write while the gate is closed, with no opening strobe in the same cycle, produces no pulse and sets the pending request.
- R4: An opening strobe (`nmi_open`) opens the gate. If a request is pending, the strobe issues one pulse in the next cycle and clears the pending request. If nothing is pending, it issues no pulse.
- R5: A closing strobe (`nmi_close`) closes the gate and leaves the pending request as it was. When both strobes arrive in the same cycle, the closing strobe wins: the gate ends closed and no pending request is flushed.
- R6: While reset is applied and after it is released, `cmd_q` is 0x00 and `nmi_pulse` is low. The gate is closed and no request is pending.
- R7: An opening strobe and a host write in the same cycle give exactly one pulse, even if a request was already pending. No request is pending afterwards.
- R8: A host write while a request is pending overwrites `cmd_q`. Any number of writes made while the gate is closed produce only one pulse on the next opening strobe.
- R9: A host write and a closing strobe in the same cycle, with the gate open before that edge, still give one pulse. The gate is closed afterwards.
- R10: When `cmd_wr` is low, `cmd_q` holds its value, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | Host write strobe, one cycle per command |
| cmd_data | input | DATA_W | Command byte from the host |
| nmi_open | input | 1 | Audio-side strobe that opens the NMI gate |
| nmi_close | input | 1 | Audio-side strobe that closes the NMI gate |
| cmd_q | output | DATA_W | Stored command byte read by the audio side |
| nmi_pulse | output | 1 | One-cycle NMI request to the audio processor |

## Verification
Host writes are tried with the gate open and with it closed. This separates immediate delivery from deferral, because only the pulse timing after a later opening strobe shows that the request was held. Bursts of masked writes followed by one opening strobe show that requests collapse to a single pulse while the last byte wins. Same-cycle pairs cover the priority and sampling rules: opening strobe with write, closing strobe with write, and both strobes together. A long constrained random run mixes all strobes with random data and compares each cycle against a model built from the requirements.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SCL_DATA_W = 8;

  typedef struct packed {
    logic open;
    logic pend;
  } scl_gate_t;
endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_d = 1'b1;
    end else begin : g_many
      assign chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/scl_data_latch.sv
module scl_data_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (ld) q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/scl_nmi_gate.sv
module scl_nmi_gate
  import scl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic open_stb,
  input  logic close_stb,
  output logic open_flag,
  output logic pend_flag,
  output logic pulse
);
  scl_gate_t st_q, st_d;
  logic      pulse_q, pulse_d;
  logic      open_eff;

  // The closing strobe wins when both strobes arrive together.
  always_comb begin
    open_eff = open_stb & ~close_stb;

    st_d = st_q;
    if (close_stb)     st_d.open = 1'b0;
    else if (open_stb) st_d.open = 1'b1;

    if (open_eff)                 st_d.pend = 1'b0;
    else if (req && !st_q.open)   st_d.pend = 1'b1;

    pulse_d = (req & (st_q.open | open_eff)) | (open_eff & st_q.pend);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
    end
  end

  assign open_flag = st_q.open;
  assign pend_flag = st_q.pend;
  assign pulse     = pulse_q;
endmodule

// File: rtl/scl_sound_mailbox.sv
module scl_sound_mailbox #(
  parameter int DATA_W     = scl_pkg::SCL_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              nmi_open,
  input  logic              nmi_close,
  output logic [DATA_W-1:0] cmd_q,
  output logic              nmi_pulse
);
  logic rst_sync_n;
  logic open_flag;
  logic pend_flag;

  scl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  scl_data_latch #(.W(DATA_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ld    (cmd_wr),
    .d     (cmd_data),
    .q     (cmd_q)
  );

  scl_nmi_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req       (cmd_wr),
    .open_stb  (nmi_open),
    .close_stb (nmi_close),
    .open_flag (open_flag),
    .pend_flag (pend_flag),
    .pulse     (nmi_pulse)
  );
endmodule

// File: rtl/scl_sound_mailbox_chk.sv
module scl_sound_mailbox_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_wr,
  input logic [W-1:0] cmd_data,
  input logic         nmi_open,
  input logic         nmi_close,
  input logic [W-1:0] cmd_q,
  input logic         nmi_pulse,
  input logic         open_flag,
  input logic         pend_flag
);
  a_r1_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> cmd_q == $past(cmd_data));

  a_r2_open_write_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && open_flag) |=> nmi_pulse);

  a_r3_masked_write_defers: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !open_flag && !nmi_open) |=> (!nmi_pulse && pend_flag));

  a_r4_open_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_open && !nmi_close && pend_flag) |=> (nmi_pulse && !pend_flag && open_flag));

  a_r5_close_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_close && !cmd_wr) |=> (!open_flag && pend_flag == $past(pend_flag)));

  a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pulse |-> $past(cmd_wr || nmi_open));

  a_r10_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q));
endmodule

bind scl_sound_mailbox scl_sound_mailbox_chk #(.W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_wr    (cmd_wr),
  .cmd_data  (cmd_data),
  .nmi_open  (nmi_open),
  .nmi_close (nmi_close),
  .cmd_q     (cmd_q),
  .nmi_pulse (nmi_pulse),
  .open_flag (open_flag),
  .pend_flag (pend_flag)
);

// File: tb/scl_sound_mailbox_tb_top.sv
`timescale 1ns/1ps
module scl_sound_mailbox_tb_top;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         cmd_wr;
  logic [W-1:0] cmd_data;
  logic         nmi_open;
  logic         nmi_close;
  logic [W-1:0] cmd_q;
  logic         nmi_pulse;

  int total = 0;
  int bad   = 0;

  // model state derived from the requirements
  logic         m_open;
  logic         m_pend;
  logic [W-1:0] m_lat;

  scl_sound_mailbox dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .nmi_open  (nmi_open),
    .nmi_close (nmi_close),
    .cmd_q     (cmd_q),
    .nmi_pulse (nmi_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_pulse(logic wr, logic op, logic cl, logic o, logic p);
    logic eff;
    eff = op & ~cl;
    return (wr & (o | eff)) | (eff & p);
  endfunction

  function automatic logic exp_pend(logic wr, logic op, logic cl, logic o, logic p);
    if (op && !cl) return 1'b0;
    if (wr && !o)  return 1'b1;
    return p;
  endfunction

  function automatic logic exp_open(logic op, logic cl, logic o);
    if (cl) return 1'b0;
    if (op) return 1'b1;
    return o;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus, wait past the edge, compare.
  task automatic step(string req, logic wr, logic [W-1:0] d, logic op, logic cl);
    logic ep;
    cmd_wr = wr; cmd_data = d; nmi_open = op; nmi_close = cl;
    ep     = exp_pulse(wr, op, cl, m_open, m_pend);
    m_pend = exp_pend(wr, op, cl, m_open, m_pend);
    m_open = exp_open(op, cl, m_open);
    if (wr) m_lat = d;
    @(posedge clk);
    #2;
    chk({req, " pulse"}, {7'd0, nmi_pulse}, {7'd0, ep});
    chk({req, " data"}, cmd_q, m_lat);
    cmd_wr = 1'b0; nmi_open = 1'b0; nmi_close = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cmd_wr = 0; cmd_data = '0; nmi_open = 0; nmi_close = 0;
    m_open = 0; m_pend = 0; m_lat = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R6 reset data", cmd_q, 8'h00);
    chk("R6 reset pulse", {7'd0, nmi_pulse}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R6 after release", {7'd0, nmi_pulse}, 8'h00);

    // R6, R3: gate closed after reset, write defers
    step("R6_R3 masked write", 1, 8'hA5, 0, 0);
    step("R10 idle hold", 0, 8'hFF, 0, 0);
    // R8: second masked write overwrites, still one pending
    step("R8 overwrite", 1, 8'h3C, 0, 0);
    // R4: opening flushes once
    step("R4 flush", 0, 8'h00, 1, 0);
    step("R4 no repeat", 0, 8'h00, 1, 0);
    // R2: open write fires
    step("R2 open write", 1, 8'h81, 0, 0);
    step("R2 back to back", 1, 8'h7E, 0, 0);
    // R9: write with close while open still fires
    step("R9 write+close", 1, 8'h11, 0, 1);
    step("R3 masked after close", 1, 8'h22, 0, 0);
    // R5: close keeps pending; simultaneous strobes, close wins
    step("R5 close keeps", 0, 8'h00, 0, 1);
    step("R5 both strobes", 0, 8'h00, 1, 1);
    step("R5 pending kept", 0, 8'h00, 1, 0);
    // R7: open + write with pending set gives one pulse
    step("R7 close", 0, 8'h00, 0, 1);
    step("R7 pend", 1, 8'h44, 0, 0);
    step("R7 open+write", 1, 8'h55, 1, 0);
    step("R7 after", 0, 8'h00, 0, 0);
    // R4: opening with nothing pending
    step("R4 close", 0, 8'h00, 0, 1);
    step("R4 empty open", 0, 8'h00, 1, 0);

    for (int i = 0; i < 2000; i++) begin
      logic wr, op, cl;
      wr = ($urandom_range(0, 99) < 40);
      op = ($urandom_range(0, 99) < 20);
      cl = ($urandom_range(0, 99) < 20);
      step("random R1_R2_R3_R4_R5", wr, 8'($urandom), op, cl);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule